// File: doc/BRIEF.md
# Tagged Token Operand Matching Unit

This block sits in front of the execution units of a dynamic dataflow processor and joins the two operands of two-input instructions. Each incoming token carries a context identifier and a destination instruction address, which together form its tag. It also carries a data value, a port bit that says which operand input it feeds, and a single-input flag. A token whose partner has not yet arrived waits in a small fully associative store that is searched on the full tag. When the partner arrives, the waiting entry is freed. An instruction packet carrying the tag and both operands then leaves on a ready/valid output.

A single-input token never touches the store. It is turned into a packet directly. The output is one register stage controlled by a two-state machine. `OUT_EMPTY` moves to `OUT_FULL` when a packet is loaded. `OUT_FULL` stays in `OUT_FULL` while the consumer stalls or while a new packet replaces the one being taken. `OUT_FULL` returns to `OUT_EMPTY` when the consumer takes the packet and nothing new is loaded. The input stalls when the output register cannot accept a packet. It also stalls when a non-matching token finds the store full.

Top module: `opmatch_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and, while the output is idle and the store is empty, `in_ready` is 1.
- R2: A two-input token pairs only with a stored token that has an equal `in_ctx`, an equal `in_addr` and the opposite `in_port`. The resulting packet appears with `out_valid`=1 on the clock after acceptance, carrying that ctx and addr and `out_single`=0.
- R3: An accepted two-input token with no partner is stored and produces no packet.
- R4: Tokens with the same address but different contexts never pair.
- R5: In a paired packet, `out_left` is the value of the port-0 token and `out_right` is the value of the port-1 token, whichever of the two arrived first.
- R6: A token with `in_single`=1 skips the store. The clock after acceptance it yields a packet with `out_single`=1, `out_left` equal to its data and `out_right`=0, and it leaves the stored tokens unchanged.
- R7: The store holds DEPTH (16) tokens. When all slots are full, `in_ready` is 0 for a two-input token without a partner. A token that has a partner is still accepted, and its match frees a slot.
- R8: While `out_valid`=1 and `out_ready`=0, the packet holds stable, `in_ready` is 0 and no token is accepted.
- R9: Tokens are written to the lowest free slot. When several stored tokens could pair, the one in the lowest slot is consumed, so every stored token is paired exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming token present |
| in_ready | output | 1 | Token accepted on this edge when in_valid is high |
| in_single | input | 1 | Token is for a single-input instruction |
| in_port | input | 1 | Operand input fed: 0 left, 1 right |
| in_ctx | input | CTX_W (4) | Context identifier |
| in_addr | input | ADDR_W (8) | Destination instruction address |
| in_data | input | DATA_W (16) | Operand value |
| out_valid | output | 1 | Instruction packet present |
| out_ready | input | 1 | Consumer takes the packet |
| out_single | output | 1 | Packet is for a single-input instruction |
| out_ctx | output | CTX_W (4) | Packet context identifier |
| out_addr | output | ADDR_W (8) | Packet instruction address |
| out_left | output | DATA_W (16) | Port-0 operand |
| out_right | output | DATA_W (16) | Port-1 operand, 0 for single-input |

## Verification
The bench builds the unit with its defaults: DEPTH 16, a 4-bit context, an 8-bit address and 16-bit data. Sixteen unmatched tokens are therefore enough to fill the store and reach the full-store stall and the accepted match while full. The 4-bit context lets one address be used in several contexts to show that different contexts stay apart. Duplicate tokens on the same port, together with a bench-side model of the slot order, expose which slot is chosen when several tokens can pair and show that no token is lost or duplicated.

// File: rtl/opmatch_pkg.sv
package opmatch_pkg;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } issue_state_e;

endpackage

// File: rtl/opmatch_store.sv
module opmatch_store #(
    parameter int DEPTH  = 16,
    parameter int CTX_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTX_W-1:0]  s_ctx,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_port,
    input  logic [DATA_W-1:0] s_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              full,
    output logic [DEPTH-1:0]  vld_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  eq;
    logic [CTX_W-1:0]  e_ctx  [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic              e_port [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  free_idx;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            assign eq[g] = vld[g] && (e_ctx[g] == s_ctx) &&
                           (e_addr[g] == s_addr) && (e_port[g] != s_port);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld[g] <= 1'b0;
                end else if (wr_en && (free_idx == IDX_W'(g))) begin
                    vld[g] <= 1'b1;
                end else if (rd_en && hit && (hit_idx == IDX_W'(g))) begin
                    vld[g] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (wr_en && (free_idx == IDX_W'(g))) begin
                    e_ctx[g]  <= s_ctx;
                    e_addr[g] <= s_addr;
                    e_port[g] <= s_port;
                    e_data[g] <= s_data;
                end
            end
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign hit_data = e_data[hit_idx];
    assign full     = &vld;
    assign vld_o    = vld;

endmodule

// File: rtl/opmatch_issue.sv
module opmatch_issue
    import opmatch_pkg::*;
#(
    parameter int CTX_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_single,
    input  logic [CTX_W-1:0]  ld_ctx,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_left,
    input  logic [DATA_W-1:0] ld_right,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic              out_single,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    issue_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (load) state_d = OUT_FULL;
            OUT_FULL:  if (out_ready && !load) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_EMPTY: begin
                out_valid = 1'b0;
                can_load  = 1'b1;
            end
            OUT_FULL: begin
                out_valid = 1'b1;
                can_load  = out_ready;
            end
            default: begin
                out_valid = 1'b0;
                can_load  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (load) begin
            out_single <= ld_single;
            out_ctx    <= ld_ctx;
            out_addr   <= ld_addr;
            out_left   <= ld_left;
            out_right  <= ld_right;
        end
    end

endmodule

// File: rtl/opmatch_unit.sv
module opmatch_unit #(
    parameter int DEPTH  = 16,
    parameter int CTX_W  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_single,
    input  logic              in_port,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_single,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    logic              cam_hit;
    logic              cam_full;
    logic [DATA_W-1:0] cam_data;
    logic [DEPTH-1:0]  cam_vld;
    logic              can_load;
    logic              take;
    logic              pair_hit;
    logic              store_wr;
    logic              store_rd;
    logic              load;
    logic [DATA_W-1:0] ld_left;
    logic [DATA_W-1:0] ld_right;

    assign pair_hit = cam_hit && !in_single;
    assign in_ready = can_load && (in_single || cam_hit || !cam_full);
    assign take     = in_valid && in_ready;
    assign store_wr = take && !in_single && !cam_hit;
    assign store_rd = take && pair_hit;
    assign load     = take && (in_single || cam_hit);

    always_comb begin
        if (in_single) begin
            ld_left  = in_data;
            ld_right = '0;
        end else if (in_port) begin
            ld_left  = cam_data;
            ld_right = in_data;
        end else begin
            ld_left  = in_data;
            ld_right = cam_data;
        end
    end

    opmatch_store #(
        .DEPTH (DEPTH),
        .CTX_W (CTX_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_ctx   (in_ctx),
        .s_addr  (in_addr),
        .s_port  (in_port),
        .s_data  (in_data),
        .wr_en   (store_wr),
        .rd_en   (store_rd),
        .hit     (cam_hit),
        .hit_data(cam_data),
        .full    (cam_full),
        .vld_o   (cam_vld)
    );

    opmatch_issue #(
        .CTX_W (CTX_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_single (in_single),
        .ld_ctx    (in_ctx),
        .ld_addr   (in_addr),
        .ld_left   (ld_left),
        .ld_right  (ld_right),
        .out_ready (out_ready),
        .can_load  (can_load),
        .out_valid (out_valid),
        .out_single(out_single),
        .out_ctx   (out_ctx),
        .out_addr  (out_addr),
        .out_left  (out_left),
        .out_right (out_right)
    );

endmodule

// File: rtl/opmatch_sva.sv
module opmatch_sva #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_single,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_single,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              cam_hit,
    input logic              cam_full,
    input logic [DEPTH-1:0]  cam_vld
);
    // R8: a stalled packet stays put
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));

    // R8: no token taken while output is stalled
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R7: full store blocks an unmatched two-input token
    assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cam_full && !cam_hit && !in_single |-> !in_ready);

    // R2 and R6: an issuing token yields a packet next cycle
    assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (cam_hit || in_single) |=> out_valid);

    // R3: a stored token produces no packet and occupies one more slot
    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !cam_hit && !in_single && (!out_valid || out_ready)
        |=> !out_valid && ($countones(cam_vld) == $past($countones(cam_vld)) + 1));

    // R6: single-input packet has a zero right operand
    assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_single |-> out_right == '0);

    // R9: a match frees exactly one slot
    assert_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cam_hit && !in_single
        |=> $countones(cam_vld) + 1 == $past($countones(cam_vld)));

endmodule

bind opmatch_unit opmatch_sva #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_single (in_single),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_single(out_single),
    .out_left  (out_left),
    .out_right (out_right),
    .cam_hit   (cam_hit),
    .cam_full  (cam_full),
    .cam_vld   (cam_vld)
);

// File: tb/opmatch_unit_tb_top.sv
module opmatch_unit_tb_top;
    localparam int DEPTH = 16;
    localparam int NV    = 13;
    // vector fields: {single, port, ctx[3:0], addr[7:0], data[15:0]}
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd1, 8'h10, 16'h1111},
        {1'b0, 1'b0, 4'd1, 8'h20, 16'h00A0},
        {1'b0, 1'b1, 4'd1, 8'h20, 16'h00B0},
        {1'b0, 1'b1, 4'd2, 8'h30, 16'h0C01},
        {1'b0, 1'b0, 4'd2, 8'h30, 16'h0C00},
        {1'b0, 1'b0, 4'd3, 8'h40, 16'h0D00},
        {1'b0, 1'b1, 4'd4, 8'h40, 16'h0D01},
        {1'b0, 1'b0, 4'd4, 8'h40, 16'h0E00},
        {1'b0, 1'b1, 4'd3, 8'h40, 16'h0E01},
        {1'b0, 1'b0, 4'd5, 8'h50, 16'h0101},
        {1'b0, 1'b0, 4'd5, 8'h50, 16'h0202},
        {1'b0, 1'b1, 4'd5, 8'h50, 16'h0303},
        {1'b0, 1'b1, 4'd5, 8'h50, 16'h0404}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_single = 1'b0, in_port = 1'b0;
    logic [3:0]  in_ctx = '0;
    logic [7:0]  in_addr = '0;
    logic [15:0] in_data = '0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, out_single;
    logic [3:0]  out_ctx;
    logic [7:0]  out_addr;
    logic [15:0] out_left, out_right;

    int errors = 0;
    int checks = 0;

    logic        m_v    [DEPTH];
    logic        m_port [DEPTH];
    logic [3:0]  m_ctx  [DEPTH];
    logic [7:0]  m_addr [DEPTH];
    logic [15:0] m_data [DEPTH];

    always #10 clk = ~clk;

    opmatch_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_single(in_single),
        .in_port(in_port), .in_ctx(in_ctx), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_single(out_single),
        .out_ctx(out_ctx), .out_addr(out_addr), .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Send one token with out_ready high; model predicts readiness and the packet.
    task automatic send(input string req, input logic sg, input logic pt,
                        input logic [3:0] cx, input logic [7:0] ad, input logic [15:0] dt);
        int hit_i, free_i;
        logic exp_rdy;
        logic [15:0] l, r;
        hit_i = -1;
        free_i = -1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_v[i] && m_ctx[i] == cx && m_addr[i] == ad && m_port[i] != pt) hit_i = i;
            if (!m_v[i]) free_i = i;
        end
        exp_rdy = sg || (hit_i >= 0) || (free_i >= 0);
        @(negedge clk);
        in_valid = 1'b1; in_single = sg; in_port = pt;
        in_ctx = cx; in_addr = ad; in_data = dt;
        #1;
        chk(req, "in_ready", {31'd0, in_ready}, {31'd0, exp_rdy});
        if (!exp_rdy) begin
            @(negedge clk);
            in_valid = 1'b0;
            return;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (sg) begin
            chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
            chk(req, "single packet", {out_single, out_ctx, out_addr, out_left},
                {1'b1, cx, ad, dt});
            chk(req, "single right", {16'd0, out_right}, 32'd0);
        end else if (hit_i >= 0) begin
            l = pt ? m_data[hit_i] : dt;
            r = pt ? dt : m_data[hit_i];
            m_v[hit_i] = 1'b0;
            chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
            chk(req, "pair tag", {23'd0, out_single, out_ctx, out_addr}, {23'd0, 1'b0, cx, ad});
            chk(req, "pair operands", {out_left, out_right}, {l, r});
        end else begin
            m_v[free_i] = 1'b1; m_port[free_i] = pt; m_ctx[free_i] = cx;
            m_addr[free_i] = ad; m_data[free_i] = dt;
            chk(req, "stored no packet", {31'd0, out_valid}, 32'd0);
        end
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

        // Table walk: R2 R3 R4 R5 R6 R9 patterns
        for (int k = 0; k < NV; k++) begin
            send("R2_R5_R9", VEC[k][29], VEC[k][28], VEC[k][27:24],
                 VEC[k][23:16], VEC[k][15:0]);
        end

        // R4: stored ctx 6 token is not paired by a ctx 7 partner
        send("R4", 1'b0, 1'b0, 4'd6, 8'h77, 16'h4600);
        send("R4", 1'b0, 1'b1, 4'd7, 8'h77, 16'h4701);
        send("R4", 1'b0, 1'b1, 4'd6, 8'h77, 16'h4601);
        send("R4", 1'b0, 1'b0, 4'd7, 8'h77, 16'h4700);

        // R6: single token while tokens are stored leaves them intact
        send("R6", 1'b0, 1'b1, 4'd9, 8'h99, 16'h9901);
        send("R6", 1'b1, 1'b1, 4'd9, 8'h99, 16'h5555);
        send("R6", 1'b0, 1'b0, 4'd9, 8'h99, 16'h9900);

        // R7: fill the store
        for (int i = 0; i < DEPTH; i++)
            send("R7", 1'b0, 1'b0, 4'd6, 8'(i), 16'h6000 + 16'(i));
        send("R7", 1'b0, 1'b0, 4'd7, 8'hE0, 16'h7000);
        send("R7", 1'b0, 1'b1, 4'd6, 8'd3, 16'h6103);
        send("R7", 1'b0, 1'b0, 4'd7, 8'hE0, 16'h7000);
        for (int i = 0; i < DEPTH; i++)
            if (i != 3) send("R7_R9", 1'b0, 1'b1, 4'd6, 8'(i), 16'h6100 + 16'(i));
        send("R7_R9", 1'b0, 1'b1, 4'd7, 8'hE0, 16'h7001);
        checks++;
        begin
            int left = 0;
            for (int i = 0; i < DEPTH; i++) if (m_v[i]) left++;
            if (left != 0) begin
                errors++;
                $display("FAIL R9 model occupancy: actual %0d expected 0", left);
            end
        end

        // R8: output backpressure
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_single = 1'b1; in_port = 1'b0;
        in_ctx = 4'd2; in_addr = 8'h42; in_data = 16'hBEEF;
        @(negedge clk);
        in_data = 16'hCAFE; in_addr = 8'h43;
        #1;
        chk("R8", "out_valid held", {31'd0, out_valid}, 32'd1);
        chk("R8", "in_ready low when stalled", {31'd0, in_ready}, 32'd0);
        repeat (2) @(negedge clk);
        #1;
        chk("R8", "packet stable", {out_addr, out_left}, {8'h42, 16'hBEEF});
        out_ready = 1'b1;
        #1;
        chk("R8", "in_ready on take", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R8", "replacement packet", {out_valid, out_addr, out_left}, {1'b1, 8'h43, 16'hCAFE});
        @(negedge clk);
        #1;
        chk("R8", "out_valid cleared", {31'd0, out_valid}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule